// File: doc/BRIEF.md
# Buffered Fast-Programming Controller for a NOR Flash Array

This block models the device side of a streaming program mode for a NOR flash array. A host opens the mode with a two-word command: a setup word followed by a confirm word. The block then runs a fixed startup check of the lock state of the target block, the programming-voltage flag and the alignment of the first-word address. After that it accepts data words as writes to that same first-word address. The words fill a 512-word buffer. Each full buffer is copied into an internal array model, and an internal counter then moves to the next buffer-sized slot of the same block.

While the mode runs, every read returns the status register and every write is treated as data, whatever its value. The host watches the buffer-free bit to pace its stream. It leaves the mode by writing to any other address. The status register then reports ready together with any error flags. Reads keep returning status until the host writes the read-array command.

Top module: `flash_stream_prog`

## Requirements
- R1: After reset `rdata` is zero and all array words read as 0xFFFF. A read strobed at one clock edge presents its data after that edge. Writing 0x00FF outside the mode makes reads return array data again.
- R2: Status bit 7 means ready. After the 0x0080 setup word and the 0x00D0 confirm word, reads return status 0x0000 for exactly CHECK_CYC cycles after the confirm write.
- R3: If the word after 0x0080 is not 0x00D0, the mode is not entered. Status reads 0x00B0, which is ready (bit 7), sequence error (bit 5) and program error (bit 4).
- R4: If a startup check fails, the mode ends with bit 7 and bit 4 set. Bit 1 is added when the target block's `blk_lock` bit is high. Bit 3 is added when `vpp_ok` is low. A first-word address whose low BUF_AW bits are non-zero sets only bit 4. Lock bits of other blocks have no effect.
- R5: While the mode accepts data, status reads 0x0001 (buffer free, not ready). Data words are stored as data, including the values 0x0070, 0x00B0 and 0x0080.
- R6: After the 512th word, bit 0 clears for 512 + COMMIT_TAIL cycles. The buffer is then free again.
- R7: Each buffer is written to 512 consecutive words of its slot. The first slot is the one holding the first-word address. Later slots follow in order and wrap to the start of the same block.
- R8: A write to any address other than the first-word address ends the mode. Status then reads 0x0080, the partial buffer is dropped, and that write does not reach the array.
- R9: Writes made during the startup check or during a commit are ignored. This holds even for writes to other addresses.
- R10: A new setup word clears the error bits left by an earlier operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for command or data |
| rd_en | input | 1 | Read strobe; data appears after the edge |
| addr | input | BUF_AW+SLOT_AW+BLK_SEL_W | Word address |
| wdata | input | DATA_W | Write data or command code |
| vpp_ok | input | 1 | Programming voltage within range |
| blk_lock | input | 2**BLK_SEL_W | Lock flag per block |
| rdata | output | DATA_W | Array word or zero-extended status |

## Verification
A wrong control state shows at the ports within one read. The status word exposes ready and buffer-free directly, so polling every cycle gives exact counts of the busy cycles in the check and commit phases. A wrong slot counter, a lost word or a missed wrap does not show until the host leaves the mode and reads the array back. For that reason the bench compares every word of both blocks against an arithmetically generated pattern.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    localparam logic [7:0] CMD_SETUP      = 8'h80;
    localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
    localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONFIRM,
        ST_CHECK,
        ST_LOAD,
        ST_COMMIT
    } fsp_state_e;

    typedef struct packed {
        logic seq_err;
        logic prg_err;
        logic vpp_err;
        logic lock_err;
    } fsp_err_t;

    // bit7 ready, bit5 sequence, bit4 program, bit3 voltage, bit1 lock, bit0 buffer free
    function automatic logic [7:0] pack_status(input logic ready, input logic buf_free,
                                               input fsp_err_t e);
        return {ready, 1'b0, e.seq_err, e.prg_err, e.vpp_err, 1'b0, e.lock_err, buf_free};
    endfunction

endpackage

// File: rtl/fsp_buf.sv
module fsp_buf #(
    parameter int DATA_W = 16,
    parameter int BUF_AW = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [BUF_AW-1:0] widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BUF_AW-1:0] ridx,
    output logic [DATA_W-1:0] rdata
);
    localparam int WORDS = 1 << BUF_AW;

    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/fsp_array.sv
module fsp_array #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/fsp_ctrl.sv
module fsp_ctrl
    import fsp_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int BUF_AW      = 9,
    parameter int BLK_AW      = 10,
    parameter int ADDR_W      = 11,
    parameter int CHECK_CYC   = 4,
    parameter int COMMIT_TAIL = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [DATA_W-1:0]                 wdata,
    input  logic                              vpp_ok,
    input  logic [(1 << (ADDR_W-BLK_AW))-1:0] blk_lock,
    output fsp_state_e                        state_o,
    output logic [ADDR_W-1:0]                 first_addr_o,
    output logic                              buf_we,
    output logic [BUF_AW-1:0]                 buf_widx,
    output logic                              commit_we,
    output logic [BUF_AW-1:0]                 commit_idx,
    output logic [ADDR_W-1:0]                 commit_addr,
    output logic [7:0]                        status,
    output logic                              status_view
);
    localparam int BUF_WORDS  = 1 << BUF_AW;
    localparam int SLOT_W     = BLK_AW - BUF_AW;
    localparam int COMMIT_LEN = BUF_WORDS + COMMIT_TAIL;
    localparam int CNT_W      = $clog2(COMMIT_LEN + CHECK_CYC + 1);

    fsp_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] first_addr;
    logic [BUF_AW-1:0] fill;
    logic [SLOT_W-1:0] slot;
    fsp_err_t          err;
    logic              show_stat;

    logic lock_bad, misalign, addr_hit, chk_done, commit_done;

    assign lock_bad    = blk_lock[first_addr[ADDR_W-1:BLK_AW]];
    assign misalign    = first_addr[BUF_AW-1:0] != '0;
    assign addr_hit    = addr == first_addr;
    assign chk_done    = cnt == CNT_W'(CHECK_CYC - 1);
    assign commit_done = cnt == CNT_W'(COMMIT_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            first_addr <= '0;
            fill       <= '0;
            slot       <= '0;
            err        <= '0;
            show_stat  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (wr_en) begin
                        if (wdata == DATA_W'(CMD_SETUP)) begin
                            state      <= ST_CONFIRM;
                            first_addr <= addr;
                            err        <= '0;
                            show_stat  <= 1'b1;
                        end else if (wdata == DATA_W'(CMD_READ_ARRAY)) begin
                            show_stat <= 1'b0;
                        end
                    end
                end
                ST_CONFIRM: begin
                    if (wr_en) begin
                        cnt <= '0;
                        if (wdata == DATA_W'(CMD_CONFIRM)) begin
                            state <= ST_CHECK;
                        end else begin
                            err.seq_err <= 1'b1;
                            err.prg_err <= 1'b1;
                            state       <= ST_IDLE;
                        end
                    end
                end
                ST_CHECK: begin
                    cnt <= cnt + 1'b1;
                    if (chk_done) begin
                        if (lock_bad || !vpp_ok || misalign) begin
                            err.prg_err  <= 1'b1;
                            err.lock_err <= lock_bad;
                            err.vpp_err  <= !vpp_ok;
                            state        <= ST_IDLE;
                        end else begin
                            fill  <= '0;
                            slot  <= first_addr[BLK_AW-1:BUF_AW];
                            state <= ST_LOAD;
                        end
                    end
                end
                ST_LOAD: begin
                    if (wr_en) begin
                        if (!addr_hit) begin
                            state <= ST_IDLE;
                        end else begin
                            fill <= fill + 1'b1;
                            if (&fill) begin
                                cnt   <= '0;
                                state <= ST_COMMIT;
                            end
                        end
                    end
                end
                ST_COMMIT: begin
                    cnt <= cnt + 1'b1;
                    if (commit_done) begin
                        slot  <= slot + 1'b1;
                        fill  <= '0;
                        state <= ST_LOAD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign state_o      = state;
    assign first_addr_o = first_addr;
    assign buf_we       = (state == ST_LOAD) && wr_en && addr_hit;
    assign buf_widx     = fill;
    assign commit_we    = (state == ST_COMMIT) && (cnt < CNT_W'(BUF_WORDS));
    assign commit_idx   = cnt[BUF_AW-1:0];
    assign commit_addr  = {first_addr[ADDR_W-1:BLK_AW], slot, cnt[BUF_AW-1:0]};
    assign status       = pack_status(state == ST_IDLE, state == ST_LOAD, err);
    assign status_view  = show_stat || (state != ST_IDLE);
endmodule

// File: rtl/flash_stream_prog.sv
module flash_stream_prog
    import fsp_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int BUF_AW      = 9,
    parameter int SLOT_AW     = 1,
    parameter int BLK_SEL_W   = 1,
    parameter int CHECK_CYC   = 4,
    parameter int COMMIT_TAIL = 8
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 wr_en,
    input  logic                                 rd_en,
    input  logic [BUF_AW+SLOT_AW+BLK_SEL_W-1:0] addr,
    input  logic [DATA_W-1:0]                    wdata,
    input  logic                                 vpp_ok,
    input  logic [(1 << BLK_SEL_W)-1:0]          blk_lock,
    output logic [DATA_W-1:0]                    rdata
);
    localparam int BLK_AW = BUF_AW + SLOT_AW;
    localparam int ADDR_W = BLK_AW + BLK_SEL_W;

    fsp_state_e        state;
    logic [ADDR_W-1:0] first_addr;
    logic              buf_we;
    logic [BUF_AW-1:0] buf_widx;
    logic              commit_we;
    logic [BUF_AW-1:0] commit_idx;
    logic [ADDR_W-1:0] commit_addr;
    logic [7:0]        status;
    logic              status_view;
    logic [DATA_W-1:0] buf_rdata;
    logic [DATA_W-1:0] arr_rdata;

    fsp_ctrl #(
        .DATA_W     (DATA_W),
        .BUF_AW     (BUF_AW),
        .BLK_AW     (BLK_AW),
        .ADDR_W     (ADDR_W),
        .CHECK_CYC  (CHECK_CYC),
        .COMMIT_TAIL(COMMIT_TAIL)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .vpp_ok      (vpp_ok),
        .blk_lock    (blk_lock),
        .state_o     (state),
        .first_addr_o(first_addr),
        .buf_we      (buf_we),
        .buf_widx    (buf_widx),
        .commit_we   (commit_we),
        .commit_idx  (commit_idx),
        .commit_addr (commit_addr),
        .status      (status),
        .status_view (status_view)
    );

    fsp_buf #(
        .DATA_W(DATA_W),
        .BUF_AW(BUF_AW)
    ) u_buf (
        .clk  (clk),
        .we   (buf_we),
        .widx (buf_widx),
        .wdata(wdata),
        .ridx (commit_idx),
        .rdata(buf_rdata)
    );

    fsp_array #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_array (
        .clk  (clk),
        .rst  (rst),
        .we   (commit_we),
        .waddr(commit_addr),
        .wdata(buf_rdata),
        .raddr(addr),
        .rdata(arr_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= status_view ? DATA_W'(status) : arr_rdata;
        end
    end
endmodule

// File: rtl/fsp_checker.sv
module fsp_checker
    import fsp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [7:0]        status,
    input fsp_state_e        state,
    input logic [ADDR_W-1:0] first_addr,
    input logic              buf_we,
    input logic              commit_we
);
    AST_SEQ_ABORT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CONFIRM && wr_en && wdata != DATA_W'(CMD_CONFIRM))
        |=> (status[7] && status[5] && status[4])) else $error("sequence abort"); // R3

    AST_ERR_ONLY_READY: assert property (@(posedge clk) disable iff (rst)
        status[4] |-> status[7]) else $error("error flag while busy"); // R4

    AST_COMMIT_BUSY: assert property (@(posedge clk) disable iff (rst)
        commit_we |-> (!status[0] && !status[7])) else $error("buffer free during commit"); // R6

    AST_COMMIT_AFTER_FILL: assert property (@(posedge clk) disable iff (rst)
        $rose(commit_we) |-> $past(buf_we)) else $error("commit without last word"); // R6

    AST_FIRST_HELD: assert property (@(posedge clk) disable iff (rst)
        (!status[7] && $past(!status[7])) |-> $stable(first_addr)) else $error("first addr moved"); // R7

    AST_EXIT_ON_MOVE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD && wr_en && addr != first_addr) |=> (status[7] && !commit_we))
        else $error("no exit on address change"); // R8

    AST_QUIET_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
        status[7] |-> (!buf_we && !commit_we)) else $error("write while ready"); // R9
endmodule

bind flash_stream_prog fsp_checker #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .status    (status),
    .state     (state),
    .first_addr(first_addr),
    .buf_we    (buf_we),
    .commit_we (commit_we)
);

// File: tb/flash_stream_prog_tb.sv
module flash_stream_prog_tb;
    localparam int CLK_PERIOD  = 10;
    localparam int BUF_AW      = 9;
    localparam int SLOT_AW     = 1;
    localparam int BLK_SEL_W   = 1;
    localparam int CHECK_CYC   = 4;
    localparam int COMMIT_TAIL = 8;
    localparam int ADDR_W      = BUF_AW + SLOT_AW + BLK_SEL_W;
    localparam int BUF_WORDS   = 1 << BUF_AW;
    localparam int BLK_WORDS   = BUF_WORDS << SLOT_AW;
    localparam int DEPTH       = 1 << ADDR_W;
    localparam int COMMIT_LEN  = BUF_WORDS + COMMIT_TAIL;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0]       wdata = '0;
    logic              vpp_ok = 1'b1;
    logic [1:0]        blk_lock = '0;
    logic [15:0]       rdata;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    flash_stream_prog #(
        .DATA_W(16), .BUF_AW(BUF_AW), .SLOT_AW(SLOT_AW), .BLK_SEL_W(BLK_SEL_W),
        .CHECK_CYC(CHECK_CYC), .COMMIT_TAIL(COMMIT_TAIL)
    ) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .vpp_ok(vpp_ok), .blk_lock(blk_lock), .rdata(rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [15:0] sdat(input int b, input int k);
        if (k == 5) return 16'h0070;
        if (k == 6) return 16'h00B0;
        if (k == 7) return 16'h0080;
        return 16'(b * 1000 + k * 7 + 3);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_n(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_wr(input int a, input int d);
        wr_en = 1'b1;
        addr  = ADDR_W'(a);
        wdata = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input int a, output logic [15:0] q);
        rd_en = 1'b1;
        addr  = ADDR_W'(a);
        @(negedge clk);
        rd_en = 1'b0;
        q = rdata;
    endtask

    // read status every cycle until bit 7 or bit 0 is set; busy = reads before that
    task automatic poll(input int a, output int busy, output logic [15:0] q);
        busy = 0;
        do_rd(a, q);
        while ((q & 16'h0081) == 16'h0000 && busy < 5000) begin
            busy++;
            do_rd(a, q);
        end
    endtask

    task automatic start(input int a);
        do_wr(a, 16'h0080);
        do_wr(a, 16'h00D0);
    endtask

    initial begin
        logic [15:0] q;
        int busy;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 rdata after reset", rdata, 16'h0000);
        do_rd(0, q);            check("R1 erased word 0", q, 16'hFFFF);
        do_rd(DEPTH - 1, q);    check("R1 erased last word", q, 16'hFFFF);

        // R3 wrong confirm word
        do_wr(0, 16'h0080);
        do_wr(0, 16'h0012);
        do_rd(0, q);            check("R3 abort status", q, 16'h00B0);
        do_rd(77, q);           check("R3 status at other addr", q, 16'h00B0);
        do_wr(0, 16'h00FF);
        do_rd(0, q);            check("R1 read-array command", q, 16'hFFFF);

        // R4 locked block, R2 check duration
        blk_lock = 2'b10;
        start(BLK_WORDS);
        poll(BLK_WORDS, busy, q);
        check_n("R2 check busy cycles", busy, CHECK_CYC);
        check("R4 lock error", q, 16'h0092);

        // R4 voltage error, other block locked only
        vpp_ok = 1'b0;
        start(0);
        poll(0, busy, q);
        check("R4 voltage error", q, 16'h0098);
        vpp_ok = 1'b1;
        blk_lock = 2'b00;

        // R4 misaligned first word
        start(5);
        poll(5, busy, q);
        check("R4 misaligned", q, 16'h0090);

        // R10 new setup clears errors; single buffer in block 0 (R7)
        start(0);
        poll(0, busy, q);
        check("R10 errors cleared", q, 16'h0001);
        for (int k = 0; k < BUF_WORDS; k++) do_wr(0, sdat(3, k));
        poll(0, busy, q);
        check_n("R6 commit busy cycles", busy, COMMIT_LEN);
        check("R6 buffer free again", q, 16'h0001);
        do_wr(BUF_WORDS, 16'h0000);
        do_rd(0, q);            check("R8 exit status", q, 16'h0080);
        do_wr(0, 16'h00FF);
        for (int a = 0; a < BLK_WORDS; a++) begin
            do_rd(a, q);
            check("R7 block0 readback", q, (a < BUF_WORDS) ? sdat(3, a) : 16'hFFFF);
        end

        // main stream: start in second slot of block 1, three buffers, wrap
        start(BLK_WORDS + BUF_WORDS);
        do_wr(BLK_WORDS + BUF_WORDS, 16'hAAAA);
        poll(BLK_WORDS + BUF_WORDS, busy, q);
        check_n("R9 write during check ignored, busy", busy, CHECK_CYC - 1);
        check("R5 load status", q, 16'h0001);
        for (int b = 0; b < 3; b++) begin
            for (int k = 0; k < BUF_WORDS; k++) do_wr(BLK_WORDS + BUF_WORDS, sdat(b, k));
            if (b == 0) begin
                do_wr(BLK_WORDS + BUF_WORDS, 16'h1234);
                do_wr(0, 16'h5555);
                poll(BLK_WORDS + BUF_WORDS, busy, q);
                check_n("R9 writes during commit ignored, busy", busy, COMMIT_LEN - 2);
            end else begin
                poll(BLK_WORDS + BUF_WORDS, busy, q);
                check_n("R6 commit busy cycles", busy, COMMIT_LEN);
            end
            check("R5 buffer free after commit", q, 16'h0001);
        end
        for (int k = 0; k < 10; k++) do_wr(BLK_WORDS + BUF_WORDS, 16'hBEEF ^ k);
        do_wr(0, 16'h9999);
        do_rd(BLK_WORDS + BUF_WORDS, q); check("R8 exit status", q, 16'h0080);
        do_rd(100, q);                   check("R8 status persists", q, 16'h0080);
        do_wr(0, 16'h00FF);
        for (int a = 0; a < DEPTH; a++) begin
            logic [15:0] e;
            if (a < BUF_WORDS)                      e = sdat(3, a);
            else if (a < BLK_WORDS)                 e = 16'hFFFF;
            else if (a < BLK_WORDS + BUF_WORDS)     e = sdat(1, a - BLK_WORDS);
            else                                    e = sdat(2, a - BLK_WORDS - BUF_WORDS);
            do_rd(a, q);
            check("R7 R8 R9 full readback", q, e);
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule